// File: doc/BRIEF.md
# Windowed Page-Map Address Translator

This block turns memory requests from four requesters into addresses for the target memory. Each request carries a requester id, an address and a valid strobe. One cycle later the block either presents the resulting address with a valid strobe, or raises a fault strobe and no access takes place. Requester 1 is the host. Its requests come through a 2 MB window. The window is cut into eight equal slices, and each slice is steered by a 4-bit selector held in a small window map. The address that comes out of the window, or the raw address of any other requester, is then handled in one of two ways. If that requester's virtual-enable bit is set, the address goes through the page map. If the bit is clear, the address is passed on unchanged.

The page map holds one entry per virtual page of 1 KB. Each entry carries a 10-bit real page number and a fault flag. An entry that has not been written since reset counts as faulted. A virtual request that lands on a faulted entry sets a sticky map-error flag, which stays set until it is explicitly cleared. The host reads and writes both maps as RAM through a simple word port. Each map entry takes two consecutive word locations, and only the odd one carries data.

Top module: `pagemap_xlate`

## Requirements
- R1: After reset, xl_valid, xl_fault, map_err and cfg_rdata are 0. Every page-map entry reads back as 0x8000. Window entry i reads back as i.
- R2: A request from requester 0, 2 or 3 whose virtual-enable bit is clear gives xl_valid=1, xl_fault=0 and xl_addr equal to req_addr on the next cycle.
- R3: A host request (req_id 1) uses req_addr[20:18] to pick a window entry. Its effective address is {selector[3:0], req_addr[17:0]}, and req_addr[21] is ignored. With virtual mode clear, this effective address appears on xl_addr.
- R4: In virtual mode, the virtual page is effective address bits [21:10]. The output is {2'b00, real page number, effective address[9:0]}.
- R5: A virtual request whose page entry has its fault flag set, or has not been written since reset, gives xl_fault=1 and xl_valid=0 on the next cycle. xl_valid and xl_fault are never high together.
- R6: map_err rises on the cycle after xl_fault and holds until a cycle with map_err_clr high. A fault and a clear in the same cycle leave map_err set.
- R7: Each request produces exactly one xl_valid or xl_fault pulse, one cycle after it is presented. A cycle without a request produces neither.
- R8: Host map port layout: cfg_addr[13]=1 selects the window map, indexed by cfg_addr[3:1], with data in bits [3:0]. cfg_addr[13]=0 selects the page map, indexed by cfg_addr[12:1], with the fault flag in bit 15 and the real page number in bits [9:0]. All other data bits read as 0.
- R9: An access with cfg_addr[0]=0 changes no entry, and a read at such an address returns 0.
- R10: cfg_rdata shows the addressed word on the cycle after cfg_rd.
- R11: A map write is used by translations presented on the following cycle. A translation presented in the same cycle as the write sees the previous contents.
- R12: The virtual-enable bit is sampled together with the request, and later changes to it do not affect that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_id | input | 2 | Requester id (1 = host) |
| req_addr | input | 22 | Request address |
| virt_en | input | 4 | Virtual-enable bit per requester |
| xl_valid | output | 1 | Translated access valid |
| xl_addr | output | 22 | Translated address |
| xl_fault | output | 1 | Request faulted, no access |
| map_err | output | 1 | Sticky map-error flag |
| map_err_clr | input | 1 | Clears map_err |
| cfg_addr | input | 14 | Host map word address |
| cfg_we | input | 1 | Host map write |
| cfg_rd | input | 1 | Host map read |
| cfg_wdata | input | 16 | Host write data |
| cfg_rdata | output | 16 | Host read data |

## Verification
Most internal faults in this block show up on the very next cycle. A window selector that is wrong, or that was reset wrongly, changes the upper bits of xl_addr on the first host request through that slice. A stale or misaddressed page entry shows up either as a wrong page number or as a fault strobe where xl_valid was expected. If the per-entry written flags are lost, unwritten pages translate instead of faulting. A map_err register that is broken is only visible one cycle after the fault pulse, so the bench compares it against its own model before each new request.

// File: rtl/pagemap_xlate.sv
module pagemap_xlate #(
  parameter int NREQ    = 4,
  parameter int HOST_ID = 1,
  parameter int WIN_W   = 21,
  parameter int SLICES  = 8,
  parameter int SEL_W   = 4,
  parameter int OFF_W   = 10,
  parameter int RPN_W   = 10,
  parameter int DW      = 16,
  localparam int ID_W   = $clog2(NREQ),
  localparam int SLC_W  = $clog2(SLICES),
  localparam int SOFF_W = WIN_W - SLC_W,
  localparam int VA_W   = SEL_W + SOFF_W,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int CFG_AW = VPN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [VA_W-1:0]   req_addr,
  input  logic [NREQ-1:0]   virt_en,
  output logic              xl_valid,
  output logic [VA_W-1:0]   xl_addr,
  output logic              xl_fault,
  output logic              map_err,
  input  logic              map_err_clr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic              cfg_rd,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata
);
  localparam int ENTRIES = 1 << VPN_W;
  localparam int PA_W    = RPN_W + OFF_W;

  logic [SEL_W-1:0]   win_q [SLICES];
  logic [RPN_W-1:0]   pm_rpn [ENTRIES];
  logic               pm_flt [ENTRIES];
  logic [ENTRIES-1:0] pm_init_q;

  logic               s_v, s_virt, s_init, s_flt;
  logic [VA_W-1:0]    s_eff;
  logic [RPN_W-1:0]   s_rpn;

  wire              is_host = req_id == ID_W'(HOST_ID);
  wire [SLC_W-1:0]  slc     = req_addr[WIN_W-1 -: SLC_W];
  wire [VA_W-1:0]   eff     = is_host ? {win_q[slc], req_addr[SOFF_W-1:0]} : req_addr;
  wire [VPN_W-1:0]  vpn     = eff[VA_W-1:OFF_W];

  wire              cfg_odd  = cfg_addr[0];
  wire              cfg_win  = cfg_addr[CFG_AW-1];
  wire [VPN_W-1:0]  cfg_idx  = cfg_addr[VPN_W:1];
  wire [SLC_W-1:0]  cfg_widx = cfg_addr[SLC_W:1];
  wire              win_we   = cfg_we & cfg_odd & cfg_win;
  wire              pm_we    = cfg_we & cfg_odd & ~cfg_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLICES; i++) win_q[i] <= SEL_W'(i);
      pm_init_q <= '0;
    end else begin
      if (win_we) win_q[cfg_widx] <= cfg_wdata[SEL_W-1:0];
      if (pm_we)  pm_init_q[cfg_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pm_we) begin
      pm_rpn[cfg_idx] <= cfg_wdata[RPN_W-1:0];
      pm_flt[cfg_idx] <= cfg_wdata[DW-1];
    end
    s_rpn <= pm_rpn[vpn];
    s_flt <= pm_flt[vpn];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_v    <= 1'b0;
      s_virt <= 1'b0;
      s_init <= 1'b0;
      s_eff  <= '0;
    end else begin
      s_v    <= req_valid;
      s_virt <= virt_en[req_id];
      s_init <= pm_init_q[vpn];
      s_eff  <= eff;
    end
  end

  wire s_fault = s_virt & (~s_init | s_flt);
  assign xl_valid = s_v & ~s_fault;
  assign xl_fault = s_v & s_fault;
  assign xl_addr  = s_virt ? VA_W'({s_rpn, s_eff[OFF_W-1:0]}) : s_eff;

  always_ff @(posedge clk) begin
    if (!rst_n)           map_err <= 1'b0;
    else if (xl_fault)    map_err <= 1'b1;
    else if (map_err_clr) map_err <= 1'b0;
  end

  logic [DW-1:0] pm_word, win_word;
  always_comb begin
    pm_word = '0;
    pm_word[DW-1] = ~pm_init_q[cfg_idx] | pm_flt[cfg_idx];
    pm_word[RPN_W-1:0] = pm_init_q[cfg_idx] ? pm_rpn[cfg_idx] : '0;
    win_word = '0;
    win_word[SEL_W-1:0] = win_q[cfg_widx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= !cfg_odd ? '0 : (cfg_win ? win_word : pm_word);
  end
endmodule

module pagemap_xlate_chk #(
  parameter int NREQ = 4,
  parameter int ID_W = 2,
  parameter int VA_W = 22,
  parameter int HOST_ID = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [ID_W-1:0] req_id,
  input logic [VA_W-1:0] req_addr,
  input logic [NREQ-1:0] virt_en,
  input logic            xl_valid,
  input logic [VA_W-1:0] xl_addr,
  input logic            xl_fault,
  input logic            map_err,
  input logic            map_err_clr
);
  AST_VALID_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(xl_valid && xl_fault)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !xl_valid && !xl_fault); // R7
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> xl_valid || xl_fault); // R7
  AST_PHYS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_id != ID_W'(HOST_ID) && !virt_en[req_id] |=> xl_valid && xl_addr == $past(req_addr)); // R2
  AST_PHYS_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n) req_valid && !virt_en[req_id] |=> !xl_fault); // R2
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n) xl_fault |=> map_err); // R6
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) map_err && !map_err_clr |=> map_err); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) map_err_clr && !xl_fault |=> !map_err); // R6
endmodule

bind pagemap_xlate pagemap_xlate_chk #(.NREQ(NREQ), .ID_W(ID_W), .VA_W(VA_W), .HOST_ID(HOST_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id), .req_addr(req_addr),
  .virt_en(virt_en), .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_fault(xl_fault),
  .map_err(map_err), .map_err_clr(map_err_clr)
);

// File: tb/pagemap_xlate_bench.sv
`timescale 1ns/1ps
module pagemap_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_id = '0;
  logic [21:0] req_addr = '0;
  logic [3:0]  virt_en = '0;
  logic        xl_valid, xl_fault, map_err;
  logic [21:0] xl_addr;
  logic        map_err_clr = 1'b0;
  logic [13:0] cfg_addr = '0;
  logic        cfg_we = 1'b0, cfg_rd = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;

  always #2 clk = ~clk;

  pagemap_xlate u_pagemap_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id), .req_addr(req_addr),
    .virt_en(virt_en), .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_fault(xl_fault),
    .map_err(map_err), .map_err_clr(map_err_clr), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  int n_chk = 0, n_fail = 0;
  logic [3:0] m_win [8];
  logic [9:0] m_rpn [4096];
  bit         m_flt [4096];
  bit         m_init [4096];
  bit         m_err = 1'b0;

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [21:0] eff_of(input logic [1:0] id, input logic [21:0] a);
    return (id == 2'd1) ? {m_win[a[20:18]], a[17:0]} : a;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [13:0] a);
    logic [11:0] ix;
    if (!a[0]) return 16'h0;
    if (a[13]) return {12'h0, m_win[a[3:1]]};
    ix = a[12:1];
    return {~m_init[ix] | m_flt[ix], 5'b0, m_init[ix] ? m_rpn[ix] : 10'h0};
  endfunction

  function automatic void model_wr(input logic [13:0] a, input logic [15:0] d);
    if (!a[0]) return;
    if (a[13]) m_win[a[3:1]] = d[3:0];
    else begin
      m_rpn[a[12:1]] = d[9:0];
      m_flt[a[12:1]] = d[15];
      m_init[a[12:1]] = 1'b1;
    end
  endfunction

  task automatic cfg_write(input logic [13:0] a, input logic [15:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic cfg_read(input logic [13:0] a, input string r);
    cfg_addr = a; cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
    check(cfg_rdata == exp_rd(a), r, 32'(cfg_rdata), 32'(exp_rd(a)));
  endtask

  task automatic expect_out(input logic [1:0] id, input logic [21:0] a, input bit virt, input string r);
    logic [21:0] e;
    logic [11:0] ix;
    bit f;
    e = eff_of(id, a);
    ix = e[21:10];
    f = virt && (!m_init[ix] || m_flt[ix]);
    check(xl_fault == f, {r, " fault"}, 32'(xl_fault), 32'(f));
    check(xl_valid == !f, {r, " valid"}, 32'(xl_valid), 32'(!f));
    if (!f)
      check(xl_addr == (virt ? {2'b00, m_rpn[ix], e[9:0]} : e), {r, " addr"}, 32'(xl_addr),
            32'(virt ? {2'b00, m_rpn[ix], e[9:0]} : e));
    if (f) m_err = 1'b1;
  endtask

  task automatic xlate(input logic [1:0] id, input logic [21:0] a, input bit virt, input string r);
    logic [3:0] ve;
    ve = 4'($urandom);
    ve[id] = virt;
    req_valid = 1'b1; req_id = id; req_addr = a; virt_en = ve;
    @(negedge clk);
    req_valid = 1'b0;
    virt_en = ~ve;
    expect_out(id, a, virt, r);
    @(negedge clk);
    check(map_err == m_err, "R6 sticky error", 32'(map_err), 32'(m_err));
    check(!xl_valid && !xl_fault, "R7 idle quiet", 32'({xl_valid, xl_fault}), 32'(0));
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8; i++) m_win[i] = 4'(i);
    for (int i = 0; i < 4096; i++) begin m_rpn[i] = '0; m_flt[i] = 1'b0; m_init[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check(!xl_valid && !xl_fault && !map_err && cfg_rdata == 16'h0, "R1 reset outputs",
          32'({xl_valid, xl_fault, map_err, cfg_rdata}), 32'(0));
    cfg_read(14'h0003, "R1 unwritten page entry");
    cfg_read(14'h200B, "R1 window reset value R10");

    xlate(2'd0, 22'h2ABCDE, 1'b0, "R2 physical iop");
    xlate(2'd3, 22'h0F00F1, 1'b0, "R2 physical exec");
    xlate(2'd1, 22'h3C1234, 1'b0, "R3 host identity window");
    cfg_write(14'h200F, 16'hFFFA);
    xlate(2'd1, 22'h1C0055, 1'b0, "R3 host remapped slice R11");
    cfg_read(14'h200F, "R8 window data bits");

    xlate(2'd2, {12'h045, 10'h001}, 1'b1, "R5 unwritten entry faults");
    map_err_clr = 1'b1;
    @(negedge clk);
    map_err_clr = 1'b0; m_err = 1'b0;
    check(map_err == 1'b0, "R6 clear", 32'(map_err), 32'(0));

    req_valid = 1'b1; req_id = 2'd2; req_addr = {12'h046, 10'h0}; virt_en = 4'hF;
    @(negedge clk);
    req_valid = 1'b0;
    check(xl_fault == 1'b1, "R5 fault pulse", 32'(xl_fault), 32'(1));
    map_err_clr = 1'b1;
    @(negedge clk);
    map_err_clr = 1'b0;
    check(map_err == 1'b1, "R6 set wins over clear", 32'(map_err), 32'(1));
    map_err_clr = 1'b1;
    @(negedge clk);
    map_err_clr = 1'b0; m_err = 1'b0;

    cfg_write(14'h0247, 16'h02F5);
    xlate(2'd3, {12'h123, 10'h3A7}, 1'b1, "R4 virtual translate");
    cfg_write(14'h0246, 16'h0011);
    cfg_read(14'h0247, "R9 even write ignored");
    cfg_read(14'h0246, "R9 even read zero");

    cfg_addr = 14'h0247; cfg_wdata = 16'h0111; cfg_we = 1'b1;
    req_valid = 1'b1; req_id = 2'd3; req_addr = {12'h123, 10'h010}; virt_en = 4'hF;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check(xl_valid && xl_addr == {2'b00, 10'h2F5, 10'h010}, "R11 same-cycle write sees old",
          32'(xl_addr), 32'({2'b00, 10'h2F5, 10'h010}));
    model_wr(14'h0247, 16'h0111);
    @(negedge clk);
    xlate(2'd3, {12'h123, 10'h010}, 1'b1, "R11 next-cycle write sees new R12");

    cfg_write(14'h0249, 16'h8155);
    cfg_read(14'h0249, "R8 fault flag readback");
    xlate(2'd0, {12'h124, 10'h2}, 1'b1, "R5 written faulted entry");
    cfg_write(14'h024B, 16'h7FFF);
    cfg_read(14'h024B, "R8 unused bits zero");
    map_err_clr = 1'b1;
    @(negedge clk);
    map_err_clr = 1'b0; m_err = 1'b0;

    for (int k = 0; k < 400; k++) begin
      int op;
      op = int'($urandom % 8);
      if (op == 0) begin
        logic [15:0] d;
        d = 16'($urandom);
        d[15] = ($urandom % 4) == 0;
        cfg_write({1'b0, 6'h0, 6'($urandom), 1'b1}, d);
      end else if (op == 1) begin
        cfg_write({1'b1, 9'($urandom), 3'($urandom), 1'($urandom)}, 16'($urandom));
      end else if (op == 2) begin
        cfg_read({1'b0, 6'h0, 6'($urandom), 1'($urandom)}, "R8 random page read");
      end else if (op == 3) begin
        cfg_read({1'b1, 9'($urandom), 3'($urandom), 1'b1}, "R8 random window read");
      end else begin
        logic [1:0] id;
        logic [21:0] a;
        id = 2'($urandom);
        a = 22'($urandom);
        if (id != 2'd1) a[21:10] = {6'h0, 6'($urandom)};
        xlate(id, a, 1'($urandom), "R4 random translate");
      end
      if (($urandom % 16) == 0) begin
        map_err_clr = 1'b1;
        @(negedge clk);
        map_err_clr = 1'b0; m_err = 1'b0;
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule